// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

This block turns a set of interrupt input wires into message writes aimed at a processor. Each wire has its own redirection entry, which holds a message data value (the vector), a mask, a trigger mode (level or edge), an active-low polarity selection and a destination identifier made of an ID byte and an extended ID byte. When an unmasked wire becomes active, the block presents one message, an address and a data word, on a valid/ready output port. The address encodes the destination. The data carries the vector.

Software reaches the block through a small memory-mapped slave. Software writes an index to a select register, then reads or writes a data window to reach that indexed register. A separate end-of-interrupt (EOI) register takes a vector value. Every line programmed with that vector is taken out of service. A level line that is still asserted then issues again.

Each wire passes through a two-flop synchronizer and is then polarity-corrected. After that, per-line logic detects a rising edge or a level. A dispatcher state machine has two states. `DS_IDLE` waits for a request. The transition *capture* (some line is requesting) latches the lowest-numbered requester and moves to `DS_OFFER`. `DS_OFFER` holds the message. The transition *accept* (valid and ready both high) returns to `DS_IDLE` and sends one issue pulse to the line that was served.

Top module: `irq_redirector`

## Requirements
- R1: After reset, every entry reads back as masked (low word 0x0001_0000), with a zero high word, and no message is offered.
- R2: The MMIO map places select at offset 0x00, the window at 0x10 and EOI at 0x40. Select reads back its index. A window read right after a window write returns the written value with unimplemented bits cleared. In the low word, bits 7:0, 13, 15 and 16 are kept, and bit 8 (lowest-priority delivery) always reads 0.
- R3: Index 0x01 is a read-only version register. Bits 7:0 hold the version (0x21 by default) and bits 23:16 hold the number of lines minus one.
- R4: The low word of line n is at index 0x10+2n and its high word is at index 0x11+2n. The high word keeps bits 31:24 (ID) and 23:16 (extended ID); its other bits read 0.
- R5: A message address is {0xFE, ID, extended ID, 0x00}, and the message data is the 8-bit vector zero-extended to 32 bits.
- R6: A line whose low-word bit 16 is set issues nothing. Clearing that bit on an already active level line produces a message.
- R7: With bit 13 set, the line is active when its wire is low. A high wire then issues nothing.
- R8: An edge line (bit 15 clear) issues exactly one message per inactive-to-active transition, however long the wire stays active.
- R9: A level line (bit 15 set) issues once and then stays silent until an EOI whose value equals its vector. If the wire is still active at that EOI, it issues again. An EOI with any other value has no effect on that line.
- R10: When several lines request at once, they are served in ascending line order.
- R11: While valid is high and ready is low, the message address and data stay stable and valid stays high.
- R12: An EOI that arrives in the same cycle as the acceptance of that line's own message does not re-arm the line. The in-service mark wins.
- R13: A level line offers its message on the third rising clock edge after its wire changes. An edge line offers its message on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmio_wr | input | 1 | Write strobe for the slave registers |
| mmio_addr | input | 8 | Register offset (select, window, EOI) |
| mmio_wdata | input | 32 | Write data |
| mmio_rdata | output | 32 | Read data for the addressed offset (combinational) |
| irq_lines | input | NUM_LINES | Asynchronous interrupt wires |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address (destination) |
| msg_data | output | 32 | Message data (vector) |

## Verification
Two functions can fall in the same clock edge: the acceptance of a level line's message and a software EOI that names that line's vector. The bench provokes the overlap by holding the offered message with ready low. It then raises ready and writes the matching EOI in the same cycle. The pass condition is that no further message appears until a second EOI is written, and that this second EOI then re-fires the still-asserted line. The priority order is swept over every non-empty subset of the four lines, with the expected message sequence computed from the subset bits.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
    localparam int REG_W = 32;
    localparam int OFF_W = 8;
    localparam int VEC_W = 8;
    localparam int ID_W  = 8;

    localparam logic [OFF_W-1:0] OFF_SELECT = 8'h00;
    localparam logic [OFF_W-1:0] OFF_WINDOW = 8'h10;
    localparam logic [OFF_W-1:0] OFF_EOI    = 8'h40;

    localparam int IDX_VERSION    = 1;
    localparam int IDX_ENTRY_BASE = 16;

    localparam int BIT_MASK   = 16;
    localparam int BIT_LEVEL  = 15;
    localparam int BIT_ACTLOW = 13;

    typedef struct packed {
        logic             masked;
        logic             level;
        logic             act_low;
        logic [VEC_W-1:0] vec;
        logic [ID_W-1:0]  dest_id;
        logic [ID_W-1:0]  dest_eid;
    } route_t;

    localparam route_t ROUTE_RESET = '{masked: 1'b1, level: 1'b0, act_low: 1'b0,
                                       vec: '0, dest_id: '0, dest_eid: '0};

    typedef enum logic [0:0] {
        DS_IDLE,
        DS_OFFER
    } disp_state_e;

    function automatic logic [REG_W-1:0] pack_low(route_t r);
        logic [REG_W-1:0] w;
        w = '0;
        w[BIT_MASK]   = r.masked;
        w[BIT_LEVEL]  = r.level;
        w[BIT_ACTLOW] = r.act_low;
        w[VEC_W-1:0]  = r.vec;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_high(route_t r);
        return {r.dest_id, r.dest_eid, {(REG_W-2*ID_W){1'b0}}};
    endfunction
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int         NUM_LINES = 4,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output route_t           routes [NUM_LINES],
    output logic             eoi_pulse,
    output logic [VEC_W-1:0] eoi_vec
);
    localparam int LAST_LINE = NUM_LINES - 1;

    logic [OFF_W-1:0] sel_q;
    route_t           ent_q [NUM_LINES];
    logic [REG_W-1:0] win_rd;
    logic             wr_sel, wr_win;

    assign wr_sel    = wr_en && (addr == OFF_SELECT);
    assign wr_win    = wr_en && (addr == OFF_WINDOW);
    assign eoi_pulse = wr_en && (addr == OFF_EOI);
    assign eoi_vec   = wdata[VEC_W-1:0];

    always_comb begin
        win_rd = '0;
        if (sel_q == OFF_W'(IDX_VERSION))
            win_rd = {8'h00, 8'(LAST_LINE), 8'h00, VERSION};
        for (int i = 0; i < NUM_LINES; i++) begin
            if (sel_q == OFF_W'(IDX_ENTRY_BASE + 2*i))
                win_rd = pack_low(ent_q[i]);
            if (sel_q == OFF_W'(IDX_ENTRY_BASE + 2*i + 1))
                win_rd = pack_high(ent_q[i]);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFF_SELECT)
            rdata = {{(REG_W-OFF_W){1'b0}}, sel_q};
        else if (addr == OFF_WINDOW)
            rdata = win_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            for (int i = 0; i < NUM_LINES; i++)
                ent_q[i] <= ROUTE_RESET;
        end else begin
            if (wr_sel)
                sel_q <= wdata[OFF_W-1:0];
            if (wr_win) begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (sel_q == OFF_W'(IDX_ENTRY_BASE + 2*i)) begin
                        ent_q[i].masked  <= wdata[BIT_MASK];
                        ent_q[i].level   <= wdata[BIT_LEVEL];
                        ent_q[i].act_low <= wdata[BIT_ACTLOW];
                        ent_q[i].vec     <= wdata[VEC_W-1:0];
                    end
                    if (sel_q == OFF_W'(IDX_ENTRY_BASE + 2*i + 1)) begin
                        ent_q[i].dest_id  <= wdata[REG_W-1 -: ID_W];
                        ent_q[i].dest_eid <= wdata[REG_W-ID_W-1 -: ID_W];
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++)
            routes[i] = ent_q[i];
    end

    AST_SELECT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) wr_sel |=> (sel_q == $past(wdata[OFF_W-1:0]))); // R2
endmodule

// File: rtl/irq_redir_line.sv
module irq_redir_line (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic act_low,
    input  logic level,
    input  logic masked,
    input  logic eoi_hit,
    input  logic issue,
    output logic req
);
    logic sync1_q, sync2_q, prev_q, pend_q, insvc_q;
    logic active, rise;

    assign active = sync2_q ^ act_low;
    assign rise   = active && !prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
            insvc_q <= 1'b0;
        end else begin
            sync1_q <= line_in;
            sync2_q <= sync1_q;
            prev_q  <= active;
            pend_q  <= (pend_q && !issue) || (rise && !masked && !level);
            if (issue && level)
                insvc_q <= 1'b1;
            else if (eoi_hit)
                insvc_q <= 1'b0;
        end
    end

    always_comb begin
        if (level)
            req = active && !masked && !insvc_q;
        else
            req = pend_q && !masked;
    end

    AST_LEVEL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) (issue && level) |=> !req); // R9
    AST_EOI_REARM: assert property (@(posedge clk) disable iff (!rst_n) (level && eoi_hit && !issue && active && !masked) |=> (req || masked || !active || !level)); // R9
endmodule

// File: rtl/irq_redir_disp.sv
module irq_redir_disp
    import irq_redir_pkg::*;
#(
    parameter int         NUM_LINES = 4,
    parameter logic [7:0] ADDR_TOP  = 8'hFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req,
    input  route_t               routes [NUM_LINES],
    input  logic                 msg_ready,
    output logic                 msg_valid,
    output logic [REG_W-1:0]     msg_addr,
    output logic [REG_W-1:0]     msg_data,
    output logic [NUM_LINES-1:0] issue
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    disp_state_e      state_q, state_d;
    logic [IDX_W-1:0] pick, cur_q;
    logic [REG_W-1:0] addr_q, data_q;

    always_comb begin
        pick = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--)
            if (req[i])
                pick = IDX_W'(i);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE:  if (req != '0) state_d = DS_OFFER;
            DS_OFFER: if (msg_ready) state_d = DS_IDLE;
            default:  state_d = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            cur_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DS_IDLE && req != '0) begin
                cur_q  <= pick;
                addr_q <= {ADDR_TOP, routes[pick].dest_id, routes[pick].dest_eid, 8'h00};
                data_q <= {{(REG_W-VEC_W){1'b0}}, routes[pick].vec};
            end
        end
    end

    always_comb begin
        msg_valid = (state_q == DS_OFFER);
        msg_addr  = addr_q;
        msg_data  = data_q;
        issue     = '0;
        if (state_q == DS_OFFER && msg_ready)
            issue[cur_q] = 1'b1;
    end

    AST_MSG_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R11
    AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(issue)); // R10
    AST_VALID_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(msg_valid) |-> $past(req != '0)); // R6
endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
    import irq_redir_pkg::*;
#(
    parameter int         NUM_LINES = 4,
    parameter logic [7:0] VERSION   = 8'h21,
    parameter logic [7:0] ADDR_TOP  = 8'hFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mmio_wr,
    input  logic [7:0]           mmio_addr,
    input  logic [31:0]          mmio_wdata,
    output logic [31:0]          mmio_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);
    route_t               routes [NUM_LINES];
    logic                 eoi_pulse;
    logic [VEC_W-1:0]     eoi_vec;
    logic [NUM_LINES-1:0] req, issue, eoi_hit;

    irq_redir_regs #(.NUM_LINES(NUM_LINES), .VERSION(VERSION)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(mmio_wr), .addr(mmio_addr),
        .wdata(mmio_wdata), .rdata(mmio_rdata), .routes(routes),
        .eoi_pulse(eoi_pulse), .eoi_vec(eoi_vec)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign eoi_hit[g] = eoi_pulse && (routes[g].vec == eoi_vec);

        irq_redir_line line_i (
            .clk(clk), .rst_n(rst_n), .line_in(irq_lines[g]),
            .act_low(routes[g].act_low), .level(routes[g].level),
            .masked(routes[g].masked), .eoi_hit(eoi_hit[g]),
            .issue(issue[g]), .req(req[g])
        );

        AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) routes[g].masked |-> !req[g]); // R6
    end

    irq_redir_disp #(.NUM_LINES(NUM_LINES), .ADDR_TOP(ADDR_TOP)) disp_i (
        .clk(clk), .rst_n(rst_n), .req(req), .routes(routes),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data), .issue(issue)
    );
endmodule

// File: tb/irq_redirector_tb_top.sv
module irq_redirector_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mmio_wr = 1'b0;
    logic [7:0]   mmio_addr = '0;
    logic [31:0]  mmio_wdata = '0;
    logic [31:0]  mmio_rdata;
    logic [N-1:0] irq_lines = '0;
    logic         msg_valid;
    logic         msg_ready = 1'b0;
    logic [31:0]  msg_addr, msg_data;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    irq_redirector dut_i (
        .clk(clk), .rst_n(rst_n), .mmio_wr(mmio_wr), .mmio_addr(mmio_addr),
        .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata), .irq_lines(irq_lines),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic mmio_write(input logic [7:0] a, input logic [31:0] d);
        mmio_wr = 1'b1; mmio_addr = a; mmio_wdata = d;
        @(negedge clk);
        mmio_wr = 1'b0;
    endtask

    task automatic ind_write(input logic [7:0] idx, input logic [31:0] v);
        mmio_write(8'h00, {24'h0, idx});
        mmio_write(8'h10, v);
    endtask

    task automatic ind_read(input logic [7:0] idx, output logic [31:0] v);
        mmio_write(8'h00, {24'h0, idx});
        mmio_addr = 8'h10;
        #1 v = mmio_rdata;
    endtask

    task automatic wait_msg(input int maxc, output bit got, output logic [31:0] a, output logic [31:0] d);
        got = 1'b0; a = '0; d = '0;
        for (int i = 0; i < maxc; i++) begin
            if (msg_valid) begin
                got = 1'b1; a = msg_addr; d = msg_data;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_msg(input string rq, input logic [31:0] ea, input logic [31:0] ed);
        bit got; logic [31:0] a, d;
        wait_msg(20, got, a, d);
        check(got, rq, {31'h0, got}, 32'h1);
        check(a == ea, rq, a, ea);
        check(d == ed, rq, d, ed);
        if (got) accept();
    endtask

    task automatic expect_quiet(input string rq, input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (msg_valid) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, rq, {31'h0, seen}, 32'h0);
    endtask

    function automatic logic [31:0] exp_addr(input int n);
        return {8'hFE, 8'(8'h10 + n), 8'(8'h80 + n), 8'h00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0x00000000 expected=0x00000001");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] a0, d0;
        bit got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!msg_valid, "R1 valid at reset", {31'h0, msg_valid}, 32'h0);
        for (int n = 0; n < N; n++) begin
            ind_read(8'(16 + 2*n), v);
            check(v == 32'h0001_0000, "R1 low word reset", v, 32'h0001_0000);
            ind_read(8'(17 + 2*n), v);
            check(v == 32'h0, "R1 high word reset", v, 32'h0);
        end

        // R3 version, R2 select readback
        ind_read(8'h01, v);
        check(v == 32'h0003_0021, "R3 version register", v, 32'h0003_0021);
        mmio_addr = 8'h00;
        #1 check(mmio_rdata == 32'h01, "R2 select readback", mmio_rdata, 32'h01);

        // R2/R4 implemented bits and index mapping sweep
        for (int n = 0; n < N; n++) begin
            ind_write(8'(16 + 2*n), 32'hFFFF_FFFF);
            mmio_addr = 8'h10;
            #1 check(mmio_rdata == 32'h0001_A0FF, "R2 low readback, bit 8 dropped", mmio_rdata, 32'h0001_A0FF);
            ind_write(8'(17 + 2*n), 32'hFFFF_FFFF);
            mmio_addr = 8'h10;
            #1 check(mmio_rdata == 32'hFFFF_0000, "R4 high readback", mmio_rdata, 32'hFFFF_0000);
        end
        for (int n = 0; n < N; n++) begin
            ind_write(8'(16 + 2*n), 32'h0001_0040 + n);
            ind_write(8'(17 + 2*n), {8'(8'h10 + n), 8'(8'h80 + n), 16'h0});
        end
        for (int n = 0; n < N; n++) begin
            ind_read(8'(16 + 2*n), v);
            check(v == 32'h0001_0040 + n, "R4 low index map", v, 32'h0001_0040 + n);
            ind_read(8'(17 + 2*n), v);
            check(v == {8'(8'h10 + n), 8'(8'h80 + n), 16'h0}, "R4 high index map", v, {8'(8'h10 + n), 8'(8'h80 + n), 16'h0});
        end

        // R13 level latency, R5 format, R9 level/EOI
        ind_write(8'h10, 32'h0000_8040);
        irq_lines[0] = 1'b1;
        @(negedge clk);
        check(!msg_valid, "R13 level not after edge 1", {31'h0, msg_valid}, 32'h0);
        @(negedge clk);
        check(!msg_valid, "R13 level not after edge 2", {31'h0, msg_valid}, 32'h0);
        @(negedge clk);
        check(msg_valid, "R13 level valid after edge 3", {31'h0, msg_valid}, 32'h1);
        check(msg_addr == exp_addr(0), "R5 address", msg_addr, exp_addr(0));
        check(msg_data == 32'h40, "R5 data", msg_data, 32'h40);
        accept();
        expect_quiet("R9 level in service", 10);
        mmio_write(8'h40, 32'h41);
        expect_quiet("R9 non-matching EOI", 10);
        mmio_write(8'h40, 32'h40);
        expect_msg("R9 matching EOI refires", exp_addr(0), 32'h40);
        irq_lines[0] = 1'b0;
        ind_write(8'h10, 32'h0001_8040);
        mmio_write(8'h40, 32'h40);

        // R8 edge line, R13 edge latency
        ind_write(8'h12, 32'h0000_0041);
        irq_lines[1] = 1'b1;
        repeat (3) @(negedge clk);
        check(!msg_valid, "R13 edge not after edge 3", {31'h0, msg_valid}, 32'h0);
        @(negedge clk);
        check(msg_valid, "R13 edge valid after edge 4", {31'h0, msg_valid}, 32'h1);
        check(msg_data == 32'h41, "R8 edge data", msg_data, 32'h41);
        accept();
        expect_quiet("R8 steady high issues once", 12);
        irq_lines[1] = 1'b0;
        repeat (5) @(negedge clk);
        irq_lines[1] = 1'b1;
        expect_msg("R8 second transition", exp_addr(1), 32'h41);
        irq_lines[1] = 1'b0;
        ind_write(8'h12, 32'h0001_0041);

        // R7 active-low polarity
        irq_lines[2] = 1'b1;
        repeat (5) @(negedge clk);
        ind_write(8'h14, 32'h0000_A042);
        expect_quiet("R7 high wire inactive", 10);
        irq_lines[2] = 1'b0;
        expect_msg("R7 low wire active", exp_addr(2), 32'h42);
        irq_lines[2] = 1'b1;
        ind_write(8'h14, 32'h0001_A042);
        mmio_write(8'h40, 32'h42);

        // R6 mask and unmask
        ind_write(8'h16, 32'h0001_8043);
        irq_lines[3] = 1'b1;
        expect_quiet("R6 masked line silent", 10);
        ind_write(8'h16, 32'h0000_8043);
        expect_msg("R6 unmask active line", exp_addr(3), 32'h43);
        irq_lines = '0;
        repeat (3) @(negedge clk);

        // R10 priority sweep over all subsets, R11 hold stable
        for (int n = 0; n < N; n++)
            ind_write(8'(16 + 2*n), 32'h0000_8050 + n);
        for (int s = 1; s < (1 << N); s++) begin
            irq_lines = '0;
            repeat (3) @(negedge clk);
            for (int n = 0; n < N; n++)
                mmio_write(8'h40, 32'h50 + n);
            irq_lines = N'(s);
            if (s == (1 << N) - 1) begin
                wait_msg(20, got, a0, d0);
                for (int k = 0; k < 5; k++) begin
                    @(negedge clk);
                    check(msg_valid && msg_addr == a0 && msg_data == d0, "R11 stable while stalled", msg_data, d0);
                end
            end
            for (int n = 0; n < N; n++)
                if (s[n])
                    expect_msg("R10 ascending order", exp_addr(n), 32'h50 + n);
            expect_quiet("R10 no extra message", 5);
        end

        // R12 EOI coinciding with acceptance
        irq_lines = '0;
        repeat (3) @(negedge clk);
        for (int n = 0; n < N; n++)
            mmio_write(8'h40, 32'h50 + n);
        irq_lines[0] = 1'b1;
        wait_msg(20, got, a0, d0);
        check(got && d0 == 32'h50, "R12 message offered", d0, 32'h50);
        msg_ready = 1'b1;
        mmio_wr = 1'b1; mmio_addr = 8'h40; mmio_wdata = 32'h50;
        @(negedge clk);
        msg_ready = 1'b0;
        mmio_wr = 1'b0;
        expect_quiet("R12 same-cycle EOI ignored", 10);
        mmio_write(8'h40, 32'h50);
        expect_msg("R12 later EOI refires", exp_addr(0), 32'h50);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule